// File: doc/BRIEF.md
# Dual-Direction Universal Bus Transceiver

This block moves data between two 36-bit ports, A and B, in either direction. Each direction has its own storage stage. The stage can be transparent, can hold its contents, or can capture on a falling edge of a per-direction strobe. Each direction also has its own pass (transparency) input, strobe input and drive-enable input. Port drive is given as a data-out bus plus a drive-enable flag for each port, so that pads or a tri-state wrapper elsewhere can turn them into bidirectional pins.

The whole block is synchronous to one fast system clock `clk`. The strobe inputs are treated as ordinary data: each is registered once on `clk`. A falling edge is recognised when the older sample is 1 and the newer sample is 0, and the capture lands on the following `clk` edge. While a pass input is high, the output mux selects the live source bus, so the path is combinationally transparent. The stored word is also refreshed every cycle during that time, so lowering pass keeps the last word seen.

Each direction runs a five-state machine. ST_PASS_HI and ST_PASS_LO mean pass is high; the suffix records the level of the last strobe sample. ST_KEEP_HI and ST_KEEP_LO mean pass is low and the word is being held. ST_LOAD means pass is low and a falling strobe edge is loading the word. The next state is chosen as follows: pass high → ST_PASS_HI or ST_PASS_LO, by the new sample; pass low, a state with the HI suffix, and a new sample of 0 → ST_LOAD; any other case with pass low → ST_KEEP_HI or ST_KEEP_LO, by the new sample. The word is written whenever the next state is a pass state or ST_LOAD. Reset enters ST_KEEP_LO.

Top module: `ubt_top`

## Requirements
- R1: While `pass_ab` is 1, `b_out` equals `a_in` in the same cycle.
- R2: While `pass_ab` is 0 and no falling strobe edge has been recognised, `b_out` stays unchanged whatever `a_in` does.
- R3: With `pass_ab` at 0, suppose `strobe_ab` is sampled at 1 on one `clk` rising edge and at 0 on the next. Then on the `clk` edge after that, the stored word takes `a_in`, and `b_out` shows it from then on.
- R4: When `pass_ab` goes from 1 to 0, `b_out` keeps the `a_in` value present at the last `clk` edge where `pass_ab` was 1.
- R5: `b_drive` is 1 exactly when `drv_ab` is 1 (active-high enable).
- R6: The B-to-A path follows R1 to R4 with `pass_ba`, `strobe_ba`, source `b_in` and output `a_out`.
- R7: `a_drive` is 1 exactly when `drv_ba_n` is 0 (active-low enable).
- R8: Reset clears both stored words to zero. `a_drive` and `b_drive` still follow their enables while reset is asserted.
- R9: With both directions transparent and both ports driven at once, `b_out` carries `a_in` and `a_out` carries `b_in` without interference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 36 | Value seen on port A |
| a_out | output | 36 | Value to drive onto port A |
| a_drive | output | 1 | Port A driver enable |
| b_in | input | 36 | Value seen on port B |
| b_out | output | 36 | Value to drive onto port B |
| b_drive | output | 1 | Port B driver enable |
| pass_ab | input | 1 | A-to-B transparency |
| strobe_ab | input | 1 | A-to-B capture strobe (falling edge) |
| drv_ab | input | 1 | B drive enable, active high |
| pass_ba | input | 1 | B-to-A transparency |
| strobe_ba | input | 1 | B-to-A capture strobe (falling edge) |
| drv_ba_n | input | 1 | A drive enable, active low |

## Verification
Directed patterns come first. One drops pass while the source keeps changing, which shows whether the word is retained or still tracks the source. One gives a lone falling strobe, which shows whether the capture lands in the correct cycle. One raises the strobe without lowering it, which separates a falling-edge capture from a rising-edge or level capture. Random cycles then mix pass, strobe and enable levels with full-width random words in both directions. This catches one direction leaking into the other, swapped enable polarities, and a capture that comes one cycle early or late. A final case drives both ports at once with distinct words to show that the two paths are independent.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
    typedef enum logic [2:0] {
        ST_PASS_LO,
        ST_PASS_HI,
        ST_KEEP_LO,
        ST_KEEP_HI,
        ST_LOAD
    } ubt_state_e;
endpackage

// File: rtl/ubt_sampler.sv
module ubt_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end
endmodule

// File: rtl/ubt_path.sv
module ubt_path
    import ubt_pkg::*;
#(
    parameter int W             = 36,
    parameter bit OE_ACTIVE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         pass,
    input  logic         strobe,
    input  logic         oe,
    output logic [W-1:0] dout,
    output logic         drive
);
    logic         smp;
    logic         was_hi;
    ubt_state_e   st_q, st_d;
    logic [W-1:0] held_q;

    ubt_sampler u_smp (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (strobe),
        .q     (smp)
    );

    // level of the strobe one sample before the newest one
    always_comb begin
        unique case (st_q)
            ST_PASS_HI, ST_KEEP_HI:            was_hi = 1'b1;
            ST_PASS_LO, ST_KEEP_LO, ST_LOAD:   was_hi = 1'b0;
            default:                           was_hi = 1'b0;
        endcase
    end

    always_comb begin
        if (pass)
            st_d = smp ? ST_PASS_HI : ST_PASS_LO;
        else if (was_hi && !smp)
            st_d = ST_LOAD;
        else
            st_d = smp ? ST_KEEP_HI : ST_KEEP_LO;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_KEEP_LO;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            unique case (st_d)
                ST_PASS_LO, ST_PASS_HI, ST_LOAD: held_q <= src;
                ST_KEEP_LO, ST_KEEP_HI:          held_q <= held_q;
                default:                         held_q <= held_q;
            endcase
        end
    end

    always_comb begin
        dout = pass ? src : held_q;
    end

    generate
        if (OE_ACTIVE_LOW) begin : g_oe_low
            assign drive = ~oe;
        end else begin : g_oe_high
            assign drive = oe;
        end
    endgenerate
endmodule

// File: rtl/ubt_top.sv
module ubt_top #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    input  logic         pass_ab,
    input  logic         strobe_ab,
    input  logic         drv_ab,
    input  logic         pass_ba,
    input  logic         strobe_ba,
    input  logic         drv_ba_n
);
    ubt_path #(.W(W), .OE_ACTIVE_LOW(1'b0)) u_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (a_in),
        .pass   (pass_ab),
        .strobe (strobe_ab),
        .oe     (drv_ab),
        .dout   (b_out),
        .drive  (b_drive)
    );

    ubt_path #(.W(W), .OE_ACTIVE_LOW(1'b1)) u_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (b_in),
        .pass   (pass_ba),
        .strobe (strobe_ba),
        .oe     (drv_ba_n),
        .dout   (a_out),
        .drive  (a_drive)
    );
endmodule

// File: rtl/ubt_checker.sv
module ubt_checker #(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_drive,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_drive,
    input logic         pass_ab,
    input logic         strobe_ab,
    input logic         drv_ab,
    input logic         pass_ba,
    input logic         strobe_ba,
    input logic         drv_ba_n
);
    logic s1_ab, s2_ab, s1_ba, s2_ba, live;
    logic fall_ab, fall_ba;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_ab <= 1'b0; s2_ab <= 1'b0;
            s1_ba <= 1'b0; s2_ba <= 1'b0;
            live  <= 1'b0;
        end else begin
            s1_ab <= strobe_ab; s2_ab <= s1_ab;
            s1_ba <= strobe_ba; s2_ba <= s1_ba;
            live  <= 1'b1;
        end
    end

    assign fall_ab = s2_ab & ~s1_ab;
    assign fall_ba = s2_ba & ~s1_ba;

    assert_pass_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pass_ab |-> (b_out == a_in));
    assert_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !pass_ab && !$past(pass_ab) && !$past(fall_ab)) |-> $stable(b_out));
    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !pass_ab && $past(fall_ab)) |-> (b_out == $past(a_in)));
    assert_retain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !pass_ab && $past(pass_ab)) |-> (b_out == $past(a_in)));
    assert_drive_b_R5: assert property (@(posedge clk)
        b_drive == drv_ab);
    assert_pass_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_ba |-> (a_out == b_in));
    assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !pass_ba && !$past(pass_ba) && !$past(fall_ba)) |-> $stable(a_out));
    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !pass_ba && $past(fall_ba)) |-> (a_out == $past(b_in)));
    assert_drive_a_R7: assert property (@(posedge clk)
        a_drive == !drv_ba_n);
endmodule

bind ubt_top ubt_checker #(.W(W)) u_chk (.*);

// File: tb/ubt_top_bench.sv
module ubt_top_bench;
    localparam int W          = 36;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_drive, b_drive;
    logic         pass_ab, strobe_ab, drv_ab, pass_ba, strobe_ba, drv_ba_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench model of the stored words and strobe history
    logic [W-1:0] m_ab, m_ba;
    logic         m1_ab, m2_ab, m1_ba, m2_ba;

    always #(CLK_PERIOD/2) clk = ~clk;

    ubt_top #(.W(W)) u_ubt_top (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
        .pass_ab(pass_ab), .strobe_ab(strobe_ab), .drv_ab(drv_ab),
        .pass_ba(pass_ba), .strobe_ba(strobe_ba), .drv_ba_n(drv_ba_n)
    );

    function automatic logic [W-1:0] rand_word();
        logic [63:0] r;
        r = {$urandom(), $urandom()};
        return r[W-1:0];
    endfunction

    function automatic logic [W-1:0] exp_b();
        return pass_ab ? a_in : m_ab;
    endfunction

    function automatic logic [W-1:0] exp_a();
        return pass_ba ? b_in : m_ba;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic f;
        if (!rst_n) begin
            m_ab = '0; m_ba = '0;
            m1_ab = 0; m2_ab = 0; m1_ba = 0; m2_ba = 0;
        end else begin
            f = m2_ab & ~m1_ab;
            if (pass_ab || f) m_ab = a_in;
            m2_ab = m1_ab; m1_ab = strobe_ab;
            f = m2_ba & ~m1_ba;
            if (pass_ba || f) m_ba = b_in;
            m2_ba = m1_ba; m1_ba = strobe_ba;
        end
    endtask

    // one clock: update the model from pre-edge inputs, then compare
    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        check(pass_ab ? "R1" : "R2/R3", b_out, exp_b());
        check("R6", a_out, exp_a());
        check("R5", {{(W-1){1'b0}}, b_drive}, {{(W-1){1'b0}}, drv_ab});
        check("R7", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, ~drv_ba_n});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] x1, x2;
        void'($urandom(32'd24681));
        rst_n = 1'b0;
        a_in = rand_word(); b_in = rand_word();
        pass_ab = 0; strobe_ab = 0; drv_ab = 1;
        pass_ba = 0; strobe_ba = 0; drv_ba_n = 0;
        tick();
        // R8: cleared words, enables live during reset
        check("R8", b_out, '0);
        check("R8", a_out, '0);
        check("R8", {{(W-1){1'b0}}, b_drive}, {{(W-1){1'b0}}, 1'b1});
        check("R8", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, 1'b1});
        drv_ab = 0; drv_ba_n = 1;
        #1;
        check("R8", {{(W-1){1'b0}}, b_drive | a_drive}, '0);
        tick();
        #2 rst_n = 1'b1;
        tick();

        // R1 then R4 retention and R2 hold
        x1 = rand_word();
        pass_ab = 1; a_in = x1;
        tick();
        check("R1", b_out, x1);
        pass_ab = 0; a_in = rand_word();
        tick();
        check("R4", b_out, x1);
        a_in = rand_word();
        tick();
        check("R2", b_out, x1);

        // rising strobe only: no capture (R2)
        strobe_ab = 1;
        tick(); tick();
        check("R2", b_out, x1);

        // falling strobe: capture one edge after the low sample (R3)
        x2 = rand_word();
        a_in = x2; strobe_ab = 0;
        tick();
        check("R3", b_out, x1);
        tick();
        check("R3", b_out, x2);
        a_in = rand_word();
        tick();
        check("R3", b_out, x2);

        // B-to-A capture (R6)
        x1 = rand_word();
        b_in = x1; strobe_ba = 1;
        tick();
        strobe_ba = 0;
        tick(); tick();
        check("R6", a_out, x1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            a_in = rand_word(); b_in = rand_word();
            pass_ab = ($urandom_range(3) == 0);
            pass_ba = ($urandom_range(3) == 0);
            if ($urandom_range(2) == 0) strobe_ab = ~strobe_ab;
            if ($urandom_range(2) == 0) strobe_ba = ~strobe_ba;
            drv_ab   = $urandom_range(1) == 1;
            drv_ba_n = $urandom_range(1) == 1;
            tick();
        end

        // R9: both directions transparent and both ports driven
        x1 = rand_word(); x2 = ~x1;
        a_in = x1; b_in = x2;
        pass_ab = 1; pass_ba = 1; drv_ab = 1; drv_ba_n = 0;
        tick();
        check("R9", b_out, x1);
        check("R9", a_out, x2);
        check("R9", {{(W-2){1'b0}}, a_drive, b_drive}, {{(W-2){1'b0}}, 2'b11});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule